// File: doc/BRIEF.md
# I/O Virtual Address Translation Unit

This block sits between a device-side DMA source and system memory and turns device addresses into system addresses. Software programs a window (a base value and a mask) and a pointer to a page directory held in system memory. A request whose address falls inside the enabled window triggers a read of one 64-bit directory entry. The entry supplies the page frame, and the request address supplies the offset within the 4 KiB page. A request outside the window, or any request while translation is off, is returned unchanged.

Only one request is in flight at a time. Requests and responses use valid/ready handshakes. The directory fetch goes out on a simple memory read port: an aligned address with a request handshake, then a data-valid strobe. Nothing is cached, so every in-window request walks the directory.

Control registers are reached through a small access port. Accesses are either 8 bytes or 4 bytes wide, and a 4-byte access picks a half of the 64-bit register with address bit 2.

Top module: `iova_xlate_top`

## Requirements
- R1: After reset, all five control registers read as zero, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: An 8-byte write (`reg_wide`=1) to any of the offsets 0x20300 (window base), 0x20308 (window mask), 0x20310 (purge command), 0x20318 (translation config) or 0x20320 (directory base) stores all 64 bits. A read returns them on `reg_rdata` in the cycle after the `reg_rd_en` strobe.
- R3: A 4-byte write (`reg_wide`=0) takes its data from `reg_wdata[31:0]`. With address bit 2 set it changes only bits 63:32 of the register, and with bit 2 clear it changes only bits 31:0. A 4-byte read returns the selected half in `reg_rdata[31:0]`, with bits 63:32 zero.
- R4: While bit 0 of the window base is 0, an accepted request produces `rsp_valid` in the next cycle. The response carries `rsp_addr` equal to the request address and `rsp_fault`=0, and no memory request is issued.
- R5: With translation enabled, a request is inside the window only when (address AND mask) equals the window base with bit 0 cleared. A request outside the window is answered exactly as in R4.
- R6: For an in-window request, `mem_req_addr` = (directory base + (address >> 12) * 8) with bits 2:0 cleared. `mem_req_valid` and the address stay steady until `mem_req_ready` is seen.
- R7: When the returned entry has bit 63 set, `rsp_addr` = entry with bits 63 and 11:0 cleared, ORed with request address bits 11:0, and `rsp_fault`=0. `rsp_valid` rises in the cycle after `mem_rsp_valid`.
- R8: When the returned entry has bit 63 clear, the response has `rsp_fault`=1 and `rsp_addr`=0.
- R9: `req_ready` is 0 from the acceptance of a request until its response is taken with `rsp_ready`. While `rsp_ready` is 0, the response stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| reg_wdata | input | 64 | Write data (4-byte writes use bits 31:0) |
| reg_rdata | output | 64 | Read data, valid the cycle after `reg_rd_en` |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | Device address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_fault | output | 1 | Directory entry was not valid |
| mem_req_valid | output | 1 | Directory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 64 | 8-byte-aligned directory entry address |
| mem_rsp_valid | input | 1 | Directory entry data valid |
| mem_rsp_data | input | 64 | Directory entry (little-endian 64-bit word) |

## Verification
The timing of each result is fixed:
- A register read shows on `reg_rdata` one edge after its strobe.
- A pass-through response is valid one edge after the accepting edge.
- A directory request is on the memory port one edge after acceptance and stays there until `mem_req_ready` is seen.
- A translated or faulted response is valid one edge after `mem_rsp_valid`.

The bench drives every input and samples every output 1 ns after a rising edge, and counts edges explicitly to reach each due cycle. It also holds `mem_req_ready` and `rsp_ready` low for extra cycles to check that the outputs hold.

// File: rtl/iova_pkg.sv
package iova_pkg;

    localparam int DATA_W      = 64;
    localparam int PAGE_SHIFT  = 12;
    localparam int ENTRY_LOG2  = 3;
    localparam int NUM_REGS    = 5;
    localparam int VALID_BIT   = DATA_W - 1;

    // register slots, in address order from the register base
    localparam int SLOT_WBASE = 0;
    localparam int SLOT_WMASK = 1;
    localparam int SLOT_PURGE = 2;
    localparam int SLOT_CFG   = 3;
    localparam int SLOT_DIR   = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_RESP
    } walk_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic              fault;
    } xl_rsp_t;

    // merge a 4- or 8-byte write into a 64-bit register
    function automatic logic [DATA_W-1:0] merge_write(
        input logic [DATA_W-1:0] old_val,
        input logic [DATA_W-1:0] wdata,
        input logic              wide,
        input logic              upper
    );
        logic [DATA_W-1:0] r;
        if (wide)       r = wdata;
        else if (upper) r = {wdata[DATA_W/2-1:0], old_val[DATA_W/2-1:0]};
        else            r = {old_val[DATA_W-1:DATA_W/2], wdata[DATA_W/2-1:0]};
        return r;
    endfunction

    // pick the half a 4-byte read returns
    function automatic logic [DATA_W-1:0] read_view(
        input logic [DATA_W-1:0] val,
        input logic              wide,
        input logic              upper
    );
        logic [DATA_W-1:0] r;
        if (wide)       r = val;
        else if (upper) r = {{(DATA_W/2){1'b0}}, val[DATA_W-1:DATA_W/2]};
        else            r = {{(DATA_W/2){1'b0}}, val[DATA_W/2-1:0]};
        return r;
    endfunction

    function automatic logic window_hit(
        input logic [DATA_W-1:0] addr,
        input logic [DATA_W-1:0] base,
        input logic [DATA_W-1:0] mask
    );
        return base[0] && ((addr & mask) == {base[DATA_W-1:1], 1'b0});
    endfunction

    function automatic logic [DATA_W-1:0] entry_address(
        input logic [DATA_W-1:0] dir_base,
        input logic [DATA_W-1:0] addr
    );
        logic [DATA_W-1:0] sum;
        sum = dir_base + ((addr >> PAGE_SHIFT) << ENTRY_LOG2);
        return {sum[DATA_W-1:ENTRY_LOG2], {ENTRY_LOG2{1'b0}}};
    endfunction

    function automatic logic [DATA_W-1:0] frame_to_phys(
        input logic [DATA_W-1:0] entry,
        input logic [DATA_W-1:0] addr
    );
        return {1'b0, entry[DATA_W-2:PAGE_SHIFT], addr[PAGE_SHIFT-1:0]};
    endfunction

endpackage

// File: rtl/xl_ctrl_regs.sv
module xl_ctrl_regs
    import iova_pkg::*;
#(
    parameter int                REG_AW   = 18,
    parameter logic [REG_AW-1:0] REG_BASE = 18'h20300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic              wide,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] win_base,
    output logic [DATA_W-1:0] win_mask,
    output logic [DATA_W-1:0] dir_base
);

    localparam int SLOT_W = REG_AW - 3;

    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic [SLOT_W-1:0] slot;
    logic              hit;
    logic              upper;

    assign slot  = addr[REG_AW-1:3] - REG_BASE[REG_AW-1:3];
    assign hit   = (slot < SLOT_W'(NUM_REGS)) && (addr[1:0] == 2'b00)
                   && (wide ? !addr[2] : 1'b1);
    assign upper = addr[2];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (wr_en && hit && (slot == SLOT_W'(g))) begin
                regs_q[g] <= merge_write(regs_q[g], wdata, wide, upper);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (hit) rdata <= read_view(regs_q[slot[2:0]], wide, upper);
            else     rdata <= '0;
        end
    end

    assign win_base = regs_q[SLOT_WBASE];
    assign win_mask = regs_q[SLOT_WMASK];
    assign dir_base = regs_q[SLOT_DIR];

endmodule

// File: rtl/xl_window.sv
module xl_window
    import iova_pkg::*;
(
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] win_base,
    input  logic [DATA_W-1:0] win_mask,
    input  logic [DATA_W-1:0] dir_base,
    output logic              hit,
    output logic [DATA_W-1:0] entry_addr
);

    assign hit        = window_hit(addr, win_base, win_mask);
    assign entry_addr = entry_address(dir_base, addr);

endmodule

// File: rtl/xl_walker.sv
module xl_walker
    import iova_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_addr,
    input  logic              win_hit,
    input  logic [DATA_W-1:0] entry_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [DATA_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_addr,
    output logic              rsp_fault
);

    walk_state_e       state_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] maddr_q;
    xl_rsp_t           rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            maddr_q <= '0;
            rsp_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        if (win_hit) begin
                            maddr_q <= entry_addr;
                            state_q <= ST_FETCH;
                        end else begin
                            rsp_q   <= '{addr: req_addr, fault: 1'b0};
                            state_q <= ST_RESP;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_data[VALID_BIT])
                            rsp_q <= '{addr: frame_to_phys(mem_rsp_data, addr_q),
                                       fault: 1'b0};
                        else
                            rsp_q <= '{addr: '0, fault: 1'b1};
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_FETCH);
    assign mem_req_addr  = maddr_q;
    assign rsp_valid     = (state_q == ST_RESP);
    assign rsp_addr      = rsp_q.addr;
    assign rsp_fault     = rsp_q.fault;

endmodule

// File: rtl/iova_xlate_top.sv
module iova_xlate_top
    import iova_pkg::*;
#(
    parameter int                REG_AW   = 18,
    parameter logic [REG_AW-1:0] REG_BASE = 18'h20300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wide,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [63:0]       rsp_addr,
    output logic              rsp_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);

    logic [DATA_W-1:0] win_base;
    logic [DATA_W-1:0] win_mask;
    logic [DATA_W-1:0] dir_base;
    logic              win_hit;
    logic [DATA_W-1:0] entry_addr;

    xl_ctrl_regs #(.REG_AW(REG_AW), .REG_BASE(REG_BASE)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wide     (reg_wide),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .win_base (win_base),
        .win_mask (win_mask),
        .dir_base (dir_base)
    );

    xl_window u_window (
        .addr       (req_addr),
        .win_base   (win_base),
        .win_mask   (win_mask),
        .dir_base   (dir_base),
        .hit        (win_hit),
        .entry_addr (entry_addr)
    );

    xl_walker u_walker (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .win_hit       (win_hit),
        .entry_addr    (entry_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_addr      (rsp_addr),
        .rsp_fault     (rsp_fault)
    );

endmodule

// File: rtl/iova_xlate_checker.sv
module iova_xlate_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_addr,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [63:0] rsp_addr,
    input logic        rsp_fault,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [63:0] mem_req_addr,
    input logic [63:0] win_base
);

    assert_passthru_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !win_base[0]) |=>
            (rsp_valid && !rsp_fault && rsp_addr == $past(req_addr) && !mem_req_valid));

    assert_mem_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_mem_align_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    assert_fault_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_addr == 64'd0));

    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));

    assert_single_R9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!rsp_valid && !mem_req_valid));

endmodule

bind iova_xlate_top iova_xlate_checker u_checker (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_addr      (rsp_addr),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .win_base      (win_base)
);

// File: tb/sim_iova_xlate_top.sv
`timescale 1ns/1ps
module sim_iova_xlate_top;

    logic        clk = 0;
    logic        rst = 1;
    logic        reg_wr_en = 0, reg_rd_en = 0, reg_wide = 0;
    logic [17:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic        req_valid = 0, req_ready;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_ready = 0, rsp_fault;
    logic [63:0] rsp_addr;
    logic        mem_req_valid, mem_req_ready = 0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [63:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    iova_xlate_top u0 (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wide(reg_wide), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [17:0] a, input logic wide, input logic [63:0] d);
        reg_wr_en = 1; reg_addr = a; reg_wide = wide; reg_wdata = d;
        step();
        reg_wr_en = 0;
    endtask

    task automatic reg_read(input logic [17:0] a, input logic wide, output logic [63:0] d);
        reg_rd_en = 1; reg_addr = a; reg_wide = wide;
        step();
        reg_rd_en = 0;
        d = reg_rdata;
    endtask

    function automatic logic [63:0] exp_entry_addr(input logic [63:0] dir, input logic [63:0] a);
        logic [63:0] s;
        s = dir + (a >> 12) * 8;
        return s & ~64'h7;
    endfunction

    function automatic logic [63:0] exp_phys(input logic [63:0] e, input logic [63:0] a);
        return (e & ~64'h8000_0000_0000_0000 & ~64'hFFF) | (a & 64'hFFF);
    endfunction

    // pass-through request; rsp held two cycles before being taken
    task automatic t_passthru(input string tag, input logic [63:0] a);
        req_valid = 1; req_addr = a;
        step();
        req_valid = 0; req_addr = 64'hDEAD_0000_0000_0000;
        chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " no mem req"}, 64'(mem_req_valid), 64'd0);
        chk({tag, " addr"}, rsp_addr, a);
        chk({tag, " fault"}, 64'(rsp_fault), 64'd0);
        chk({tag, " R9 busy"}, 64'(req_ready), 64'd0);
        step();
        chk({tag, " R9 hold"}, rsp_addr, a);
        rsp_ready = 1;
        step();
        rsp_ready = 0;
        chk({tag, " R9 ready again"}, 64'(req_ready), 64'd1);
        chk({tag, " R9 rsp cleared"}, 64'(rsp_valid), 64'd0);
    endtask

    // directory walk request
    task automatic t_walk(input string tag, input logic [63:0] a, input logic [63:0] dir,
                          input logic [63:0] entry);
        logic [63:0] ea;
        ea = exp_entry_addr(dir, a);
        req_valid = 1; req_addr = a;
        step();
        req_valid = 0;
        chk({tag, " R6 mem valid"}, 64'(mem_req_valid), 64'd1);
        chk({tag, " R6 mem addr"}, mem_req_addr, ea);
        chk({tag, " R9 busy"}, 64'(req_ready), 64'd0);
        step();
        chk({tag, " R6 held"}, 64'(mem_req_valid), 64'd1);
        chk({tag, " R6 addr held"}, mem_req_addr, ea);
        mem_req_ready = 1;
        step();
        mem_req_ready = 0;
        chk({tag, " R6 req dropped"}, 64'(mem_req_valid), 64'd0);
        step();
        chk({tag, " R7 no early rsp"}, 64'(rsp_valid), 64'd0);
        mem_rsp_valid = 1; mem_rsp_data = entry;
        step();
        mem_rsp_valid = 0; mem_rsp_data = '0;
        chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        if (entry[63]) begin
            chk({tag, " R7 addr"}, rsp_addr, exp_phys(entry, a));
            chk({tag, " R7 fault"}, 64'(rsp_fault), 64'd0);
        end else begin
            chk({tag, " R8 fault"}, 64'(rsp_fault), 64'd1);
            chk({tag, " R8 addr"}, rsp_addr, 64'd0);
        end
        rsp_ready = 1;
        step();
        rsp_ready = 0;
        chk({tag, " R9 ready again"}, 64'(req_ready), 64'd1);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        for (int i = 0; i < 5; i++) begin
            reg_read(18'h20300 + 18'(i * 8), 1'b1, d);
            chk("R1 reg zero", d, 64'd0);
        end
    endtask

    task automatic t_wide_regs();
        logic [63:0] d;
        for (int i = 0; i < 5; i++) begin
            reg_write(18'h20300 + 18'(i * 8), 1'b1, 64'h0123_4567_89AB_CD00 + 64'(i));
        end
        for (int i = 0; i < 5; i++) begin
            reg_read(18'h20300 + 18'(i * 8), 1'b1, d);
            chk("R2 round trip", d, 64'h0123_4567_89AB_CD00 + 64'(i));
        end
    endtask

    task automatic t_half_regs();
        logic [63:0] d;
        reg_write(18'h20308, 1'b1, 64'h1111_2222_3333_4444);
        reg_write(18'h2030C, 1'b0, 64'hFFFF_FFFF_AAAA_BBBB);
        reg_read(18'h20308, 1'b1, d);
        chk("R3 upper write", d, 64'hAAAA_BBBB_3333_4444);
        reg_read(18'h20308, 1'b0, d);
        chk("R3 low half read", d, 64'h0000_0000_3333_4444);
        reg_read(18'h2030C, 1'b0, d);
        chk("R3 high half read", d, 64'h0000_0000_AAAA_BBBB);
        reg_write(18'h20308, 1'b0, 64'hEEEE_EEEE_5555_6666);
        reg_read(18'h20308, 1'b1, d);
        chk("R3 lower write", d, 64'hAAAA_BBBB_5555_6666);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(); step(); step();
        rst = 0;
        step();
        t_reset();
        t_wide_regs();
        t_half_regs();
        // R4: translation disabled (base bit 0 clear), address matches window
        reg_write(18'h20300, 1'b1, 64'h0000_0000_8000_0000);
        reg_write(18'h20308, 1'b1, 64'hFFFF_FFFF_F000_0000);
        reg_write(18'h20320, 1'b1, 64'h0000_0000_0010_0000);
        t_passthru("R4 disabled", 64'h0000_0000_8123_4567);
        // R5: enabled, outside window
        reg_write(18'h20300, 1'b1, 64'h0000_0000_8000_0001);
        t_passthru("R5 outside", 64'h0000_0000_9000_0010);
        t_passthru("R5 upper bits", 64'h0000_0001_8123_4567);
        // R6/R7: inside window, valid entry
        t_walk("R7 valid", 64'h0000_0000_8123_4567, 64'h0000_0000_0010_0000,
               64'h8000_00AB_CDEF_5123);
        // R6: unaligned directory base rounds down
        reg_write(18'h20320, 1'b1, 64'h0000_0000_0010_0004);
        t_walk("R6 unaligned dir", 64'h0000_0000_8FFF_FFFF, 64'h0000_0000_0010_0004,
               64'hFFFF_FFFF_FFFF_FFFF);
        // R8: invalid entry
        t_walk("R8 invalid", 64'h0000_0000_8000_0ABC, 64'h0000_0000_0010_0004,
               64'h0000_1234_5678_9000);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule